// File: doc/BRIEF.md
# Address Decoder with Character Terminal Port

This block sits on the bus of a small 8-bit processor system. It splits the 64 KiB address space into three fixed regions and produces one chip select for each: a RAM window in the lowest quarter, a terminal I/O window in the second quarter and a ROM window in the upper half. The RAM and ROM arrays sit outside the block and only see the selects.

The I/O window reaches a single character terminal port, whatever the low 14 address bits are. Keystrokes arrive on a valid/code pair and queue in a small FIFO. A read of the port hands back the oldest queued character, or zero when nothing is queued. While characters are waiting, an active-low interrupt line is held low. A write to the port is a command, chosen by the data byte:
- zero empties the key queue;
- a byte with the top bit set clears the screen and homes the cursor;
- ten starts a new line;
- any other byte is printed as a character.

Every register updates on the falling edge of the bus clock, which is the edge where the processor latches its data. Screen commands appear as one-clock pulses to a renderer outside the block.

Top module: `mem_term_port`

## Requirements
- R1: An address with bits [15:14] = 00 asserts only `ram_cs`, 01 asserts only `io_cs`, and 1x asserts only `rom_cs`; exactly one select is high at any time.
- R2: Inside the I/O window the low 14 address bits have no effect: 0x4000, 0x5A5A and 0x7FFF reach the same port.
- R3: During an I/O read (`rd_nwr` = 1), `rdata` shows the oldest queued keystroke, in arrival order, or 0x00 when the queue is empty. Outside an I/O read `rdata` is 0x00.
- R4: One I/O read access, contiguous clocks with `io_cs` and `rd_nwr` high, removes at most one character, at the falling edge of its first clock. `rdata` keeps that character for the rest of the access, and a read of an empty queue removes nothing.
- R5: An I/O write of 0x00 empties the queue. A keystroke arriving in the same clock is discarded too.
- R6: An I/O write of 0x80 to 0xFF produces a one-clock `scr_clear` pulse.
- R7: An I/O write of 0x0A produces a one-clock `scr_newline` pulse. Any other value from 0x01 to 0x7F produces a one-clock `scr_put` pulse with the value on `scr_char`. A write held over several clocks issues one command only.
- R8: `irq_n` is low exactly when the queue holds at least one unread character.
- R9: The queue holds 16 characters. Keystrokes that arrive while it is full and no character leaves are dropped.
- R10: Synchronous reset empties the queue, drives `irq_n` high and keeps all screen pulses low.
- R11: Registers update on the falling edge of `clk`. A screen pulse is high from the falling edge that ends the first clock of the write until the next falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; state changes on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Bus address |
| wdata | input | 8 | Data written by the processor |
| rd_nwr | input | 1 | 1 = read cycle, 0 = write cycle |
| key_valid | input | 1 | A keystroke is offered this clock |
| key_code | input | 8 | Code of the offered keystroke |
| ram_cs | output | 1 | RAM region select |
| io_cs | output | 1 | Terminal port select |
| rom_cs | output | 1 | ROM region select |
| rdata | output | 8 | Read data from the terminal port |
| irq_n | output | 1 | Active-low interrupt, low while input is pending |
| scr_put | output | 1 | Pulse: print `scr_char` |
| scr_char | output | 8 | Character for `scr_put` |
| scr_newline | output | 1 | Pulse: start a new line |
| scr_clear | output | 1 | Pulse: clear screen and home cursor |

## Verification
The hardest case to reach from the ports is a full queue meeting a new keystroke. The bench offers twenty keys back to back with no reads in between, then drains the queue with sixteen separate read accesses. Those reads must return exactly the first sixteen codes in order, and one more read must return zero. A second hard case is a flush write in the same clock as an arriving keystroke: the bench drives both together and then expects an empty read and `irq_n` high. Reads and writes held over several clocks are checked clock by clock, to show that the queue and the screen each see a single event.

// File: rtl/mem_term_pkg.sv
package mem_term_pkg;

    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 8;
    localparam int KEY_SLOTS = 16;

    localparam logic [DATA_W-1:0] CODE_FLUSH   = 8'h00;
    localparam logic [DATA_W-1:0] CODE_NEWLINE = 8'h0A;

    typedef enum logic [1:0] {
        SPACE_RAM = 2'd0,
        SPACE_IO  = 2'd1,
        SPACE_ROM = 2'd2
    } space_e;

    typedef struct packed {
        logic              flush;
        logic              clear;
        logic              newline;
        logic              put;
        logic [DATA_W-1:0] ch;
    } term_cmd_t;

    function automatic space_e space_of(input logic [1:0] top_bits);
        if (top_bits[1])      return SPACE_ROM;
        else if (top_bits[0]) return SPACE_IO;
        else                  return SPACE_RAM;
    endfunction

    function automatic term_cmd_t classify_write(input logic [DATA_W-1:0] b);
        term_cmd_t c;
        c = '0;
        c.ch = b;
        if (b == CODE_FLUSH)        c.flush   = 1'b1;
        else if (b[DATA_W-1])       c.clear   = 1'b1;
        else if (b == CODE_NEWLINE) c.newline = 1'b1;
        else                        c.put     = 1'b1;
        return c;
    endfunction

endpackage

// File: rtl/region_decode.sv
module region_decode
    import mem_term_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    output logic          ram_sel,
    output logic          io_sel,
    output logic          rom_sel
);
    space_e space;

    always_comb begin
        space   = space_of(addr[AW-1 -: 2]);
        ram_sel = (space == SPACE_RAM);
        io_sel  = (space == SPACE_IO);
        rom_sel = (space == SPACE_ROM);
    end

    // R1
    sel_onehot_chk: assert property (@(negedge clk) disable iff (rst)
        $countones({ram_sel, io_sel, rom_sel}) == 1);

    // R1
    rom_upper_chk: assert property (@(negedge clk) disable iff (rst)
        addr[AW-1] |-> rom_sel);

endmodule

// File: rtl/key_queue.sv
module key_queue #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    input  logic         flush,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

    logic [W-1:0]     slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             push_ok, pop_ok;

    assign empty   = (count == '0);
    assign full    = (count == FULL_CNT);
    assign head    = slots[rd_ptr];
    assign pop_ok  = pop && !empty && !flush;
    assign push_ok = push && !flush && (!full || pop_ok);

    always_ff @(negedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                slots[wr_ptr] <= din;
                wr_ptr <= (wr_ptr == LAST_SLOT) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok)
                rd_ptr <= (rd_ptr == LAST_SLOT) ? '0 : rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R9
    full_drop_chk: assert property (@(negedge clk) disable iff (rst)
        (full && push && !pop && !flush) |=> full);

    // R4
    empty_no_pop_chk: assert property (@(negedge clk) disable iff (rst)
        (empty && !push) |=> empty);

    // R5
    flush_empties_chk: assert property (@(negedge clk) disable iff (rst)
        flush |=> empty);

endmodule

// File: rtl/term_cmd_unit.sv
module term_cmd_unit
    import mem_term_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_first,
    input  logic [DATA_W-1:0] wdata,
    output logic              flush_now,
    output logic              put_q,
    output logic [DATA_W-1:0] char_q,
    output logic              newline_q,
    output logic              clear_q
);
    term_cmd_t cmd;

    always_comb begin
        cmd       = classify_write(wdata);
        flush_now = wr_first && cmd.flush;
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            put_q     <= 1'b0;
            newline_q <= 1'b0;
            clear_q   <= 1'b0;
            char_q    <= '0;
        end else begin
            put_q     <= wr_first && cmd.put;
            newline_q <= wr_first && cmd.newline;
            clear_q   <= wr_first && cmd.clear;
            if (wr_first && cmd.put)
                char_q <= cmd.ch;
        end
    end

    // R7
    one_cmd_chk: assert property (@(negedge clk) disable iff (rst)
        $onehot0({put_q, newline_q, clear_q}));

    // R7
    pulse_once_chk: assert property (@(negedge clk) disable iff (rst)
        (put_q && !wr_first) |=> !put_q);

endmodule

// File: rtl/mem_term_port.sv
module mem_term_port
    import mem_term_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int DW    = DATA_W,
    parameter int DEPTH = KEY_SLOTS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          rd_nwr,
    input  logic          key_valid,
    input  logic [DW-1:0] key_code,
    output logic          ram_cs,
    output logic          io_cs,
    output logic          rom_cs,
    output logic [DW-1:0] rdata,
    output logic          irq_n,
    output logic          scr_put,
    output logic [DW-1:0] scr_char,
    output logic          scr_newline,
    output logic          scr_clear
);
    logic          io_rd, io_wr, rd_prev, wr_prev, rd_first, wr_first;
    logic          q_empty, q_full, flush_now;
    logic [DW-1:0] q_head, held_byte;

    region_decode #(.AW(AW)) u_dec (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .ram_sel (ram_cs),
        .io_sel  (io_cs),
        .rom_sel (rom_cs)
    );

    assign io_rd    = io_cs && rd_nwr;
    assign io_wr    = io_cs && !rd_nwr;
    assign rd_first = io_rd && !rd_prev;
    assign wr_first = io_wr && !wr_prev;

    always_ff @(negedge clk) begin
        if (rst) begin
            rd_prev   <= 1'b0;
            wr_prev   <= 1'b0;
            held_byte <= '0;
        end else begin
            rd_prev <= io_rd;
            wr_prev <= io_wr;
            if (rd_first)
                held_byte <= q_empty ? '0 : q_head;
        end
    end

    key_queue #(.DEPTH(DEPTH), .W(DW)) u_queue (
        .clk   (clk),
        .rst   (rst),
        .push  (key_valid),
        .din   (key_code),
        .pop   (rd_first),
        .flush (flush_now),
        .head  (q_head),
        .empty (q_empty),
        .full  (q_full)
    );

    term_cmd_unit u_cmd (
        .clk       (clk),
        .rst       (rst),
        .wr_first  (wr_first),
        .wdata     (wdata[DATA_W-1:0]),
        .flush_now (flush_now),
        .put_q     (scr_put),
        .char_q    (scr_char),
        .newline_q (scr_newline),
        .clear_q   (scr_clear)
    );

    always_comb begin
        if (!io_rd)        rdata = '0;
        else if (rd_prev)  rdata = held_byte;
        else if (q_empty)  rdata = '0;
        else               rdata = q_head;
    end

    assign irq_n = q_empty;

    // R10
    reset_quiet_chk: assert property (@(negedge clk)
        rst |=> (irq_n && !scr_put && !scr_clear && !scr_newline));

    // R4
    held_read_chk: assert property (@(negedge clk) disable iff (rst)
        (io_rd && rd_prev) |=> (!io_rd || rdata == $past(rdata)) || !rd_prev);

endmodule

// File: tb/mem_term_port_tb.sv
`timescale 1ns/1ps
module mem_term_port_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] addr;
    logic [7:0]  wdata;
    logic        rd_nwr;
    logic        key_valid;
    logic [7:0]  key_code;
    logic        ram_cs, io_cs, rom_cs, irq_n;
    logic        scr_put, scr_newline, scr_clear;
    logic [7:0]  rdata, scr_char;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    mem_term_port u_dut (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .rd_nwr(rd_nwr),
        .key_valid(key_valid), .key_code(key_code),
        .ram_cs(ram_cs), .io_cs(io_cs), .rom_cs(rom_cs), .rdata(rdata),
        .irq_n(irq_n), .scr_put(scr_put), .scr_char(scr_char),
        .scr_newline(scr_newline), .scr_clear(scr_clear)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_idle();
        addr = 16'h0000; rd_nwr = 1'b1; wdata = 8'h00; key_valid = 1'b0; key_code = 8'h00;
    endtask

    task automatic do_reset();
        tick(); rst = 1'b1; set_idle();
        tick(); tick(); rst = 1'b0;
        tick();
    endtask

    task automatic push_key(input logic [7:0] code);
        tick(); key_valid = 1'b1; key_code = code;
        tick(); key_valid = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, input logic [7:0] exp, input string tag);
        tick(); addr = a; rd_nwr = 1'b1;
        #3 check(tag, rdata, exp);
        tick(); set_idle();
    endtask

    task automatic io_write(input logic [7:0] d, output logic p, output logic n,
                            output logic c, output logic [7:0] ch, output logic after);
        tick(); addr = 16'h4000; rd_nwr = 1'b0; wdata = d;
        tick(); set_idle();
        #3; p = scr_put; n = scr_newline; c = scr_clear; ch = scr_char;
        tick(); #3;
        after = scr_put | scr_newline | scr_clear;
    endtask

    task automatic t_reset();
        do_reset();
        check("R10 irq_n after reset", irq_n, 1);
        check("R10 pulses after reset", {scr_put, scr_newline, scr_clear}, 0);
        io_read(16'h4000, 8'h00, "R10 read after reset empty");
        push_key(8'h61);
        check("R10 irq before reset", irq_n, 0);
        do_reset();
        check("R10 irq cleared by reset", irq_n, 1);
        io_read(16'h4000, 8'h00, "R10 queue emptied by reset");
    endtask

    task automatic t_decode();
        logic [15:0] probes [8] = '{16'h0000, 16'h3FFF, 16'h4000, 16'h5A5A,
                                    16'h7FFF, 16'h8000, 16'hC123, 16'hFFFF};
        logic [2:0]  want   [8] = '{3'b100, 3'b100, 3'b010, 3'b010,
                                    3'b010, 3'b001, 3'b001, 3'b001};
        for (int i = 0; i < 8; i++) begin
            tick(); addr = probes[i]; rd_nwr = 1'b1;
            #3 check($sformatf("R1 selects @%h", probes[i]), {ram_cs, io_cs, rom_cs}, want[i]);
        end
        tick(); set_idle();
        #3 check("R3 rdata zero outside io", rdata, 0);
    endtask

    task automatic t_read_order();
        do_reset();
        push_key(8'h41); push_key(8'h42); push_key(8'h43);
        #3 check("R8 irq low with input", irq_n, 0);
        tick(); addr = 16'h4000; rd_nwr = 1'b1;
        #3 check("R3 first char", rdata, 8'h41);
        for (int k = 0; k < 3; k++) begin
            tick();
            #3 check("R4 held read stable", rdata, 8'h41);
        end
        tick(); set_idle();
        io_read(16'h7FFF, 8'h42, "R2 R4 second char via 7FFF");
        io_read(16'h5A5A, 8'h43, "R2 third char via 5A5A");
        #3 check("R8 irq high when drained", irq_n, 1);
        io_read(16'h4000, 8'h00, "R3 empty read zero");
        push_key(8'h44);
        io_read(16'h4000, 8'h44, "R4 empty read popped nothing");
    endtask

    task automatic t_full();
        do_reset();
        for (int i = 0; i < 20; i++) push_key(8'h30 + 8'(i));
        for (int i = 0; i < 16; i++)
            io_read(16'h4000, 8'h30 + 8'(i), $sformatf("R9 drain slot %0d", i));
        io_read(16'h4000, 8'h00, "R9 overflow keys dropped");
        #3 check("R9 irq after drain", irq_n, 1);
    endtask

    task automatic t_flush();
        logic p, n, c, after; logic [7:0] ch;
        do_reset();
        push_key(8'h11); push_key(8'h12); push_key(8'h13);
        io_write(8'h00, p, n, c, ch, after);
        check("R5 flush no screen pulse", {p, n, c}, 0);
        check("R5 irq high after flush", irq_n, 1);
        io_read(16'h4000, 8'h00, "R5 read after flush");
        tick(); addr = 16'h6000; rd_nwr = 1'b0; wdata = 8'h00; key_valid = 1'b1; key_code = 8'h55;
        tick(); set_idle();
        #3 check("R5 concurrent key discarded irq", irq_n, 1);
        io_read(16'h4000, 8'h00, "R5 concurrent key discarded");
    endtask

    task automatic t_screen();
        logic p, n, c, after; logic [7:0] ch;
        int pulses;
        do_reset();
        io_write(8'h41, p, n, c, ch, after);
        check("R7 put pulse", {p, n, c}, 3'b100);
        check("R7 put char", ch, 8'h41);
        check("R11 put one clock", after, 0);
        io_write(8'h0A, p, n, c, ch, after);
        check("R7 newline pulse", {p, n, c}, 3'b010);
        io_write(8'h01, p, n, c, ch, after);
        check("R7 low char put", {p, n, c, ch}, {3'b100, 8'h01});
        io_write(8'h7F, p, n, c, ch, after);
        check("R7 top char put", {p, n, c, ch}, {3'b100, 8'h7F});
        io_write(8'h80, p, n, c, ch, after);
        check("R6 clear on 80", {p, n, c}, 3'b001);
        check("R11 clear one clock", after, 0);
        io_write(8'hFF, p, n, c, ch, after);
        check("R6 clear on FF", {p, n, c}, 3'b001);
        pulses = 0;
        tick(); addr = 16'h4321; rd_nwr = 1'b0; wdata = 8'h5A;
        #3 check("R11 no pulse before falling edge", scr_put, 0);
        for (int k = 0; k < 4; k++) begin
            tick();
            if (k == 2) set_idle();
            #3 pulses += int'(scr_put);
        end
        check("R7 held write single put", pulses, 1);
    endtask

    initial begin
        rst = 1'b1;
        set_idle();
        t_reset();
        t_decode();
        t_read_order();
        t_full();
        t_flush();
        t_screen();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule